// File: doc/BRIEF.md
# Strobed Parallel Register Bus Slave

This block gives a host processor read and write access to a bank of byte-wide internal registers over a small asynchronous parallel bus. The bus has an address, a data path that the block drives only during reads, a read/write select, an active-low address strobe, an active-low chip select and an active-low acknowledge. None of the bus inputs have a timing relationship to the system clock. The block passes the strobes through a synchronizer chain and finds their edges in the system clock domain. Tri-state pads are modelled as a data value plus an output enable.

The host opens a cycle by pulling the address strobe low with the address already on the bus. It then pulls chip select low, and the read/write select determines the direction of the cycle. On a read, the block places the addressed byte on the bus and acknowledges one clock later. The byte is held until chip select goes high again. On a write, the data may settle some time after chip select falls, so the block takes the byte and commits it only when chip select rises. It then acknowledges for a fixed number of clocks.

A strap input selects serial operation. In that mode the parallel port ignores everything on its pins, so the pins can be reused.

Top module: `pbus_reg_slave`

## Requirements
- R1: After reset every register reads back as 0x00, and both the data output enable and the acknowledge output enable are low.
- R2: The target register is the value on the address lines at the falling edge of the address strobe. Changes to the address lines while the strobe stays low do not move the access.
- R3: A write stores the byte present on the data lines when chip select rises. A different byte present when chip select falls is not stored.
- R4: On a read (read/write select high = read), the block drives the addressed byte with the data output enable high. The byte stays unchanged until chip select rises, and the enable is low again within a few clocks after that.
- R5: On a read, the acknowledge enable goes high exactly one system clock after the data enable goes high. It goes low when chip select returns high.
- R6: After a write commits, the acknowledge enable is high for WR_ACK_LEN system clocks (default 2) and then low.
- R7: The data output enable is never high during a write cycle or while the bus is idle.
- R8: While the serial-mode input is high, bus activity causes no data enable, no acknowledge, and no change to any register.
- R9: Whenever the acknowledge enable is high, the acknowledge level is low (active).
- R10: A sequence of random writes and reads returns, on every read, the byte last written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| serial_mode | input | 1 | High selects serial use of the pins; parallel port is ignored |
| hb_addr | input | ADDR_W | Register address from the host |
| hb_as_n | input | 1 | Active-low address strobe |
| hb_cs_n | input | 1 | Active-low chip select |
| hb_rnw | input | 1 | 1 = read, 0 = write |
| hb_data_in | input | DATA_W | Data from the host pad |
| hb_data_out | output | DATA_W | Read data toward the pad |
| hb_data_oe | output | 1 | Data pad output enable |
| hb_ack_n | output | 1 | Acknowledge level (active low) |
| hb_ack_oe | output | 1 | Acknowledge pad output enable |

## Verification
The hardest case to reach from the ports is a write where the data lines hold a wrong byte when chip select falls and the correct byte only appears later. In the same cycle the address lines move while the address strobe is still low. Directed cycles set up both conditions, with the correct byte held past the rise of chip select, and the register is then read back. Serial-mode isolation is checked by running complete write cycles with the strap high and then reading the same registers back with the strap low. Random traffic is compared against a register model kept in the bench.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD_DRIVE,
      ST_RD_ACK,
      ST_WR_WAIT,
      ST_WR_ACK
   } pbus_state_e;
endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
   parameter int WIDTH   = 1,
   parameter int STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pbus_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] stg [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= RST_VAL;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[i] <= RST_VAL;
            else        stg[i] <= stg[i-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/pbus_reg_bank.sv
module pbus_reg_bank #(
   parameter int ADDR_W = 5,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (wr_en) begin
         mem[addr] <= wr_data;
      end
   end

   assign rd_data = mem[addr];
endmodule

// File: rtl/pbus_ctrl.sv
module pbus_ctrl
   import pbus_pkg::*;
#(
   parameter int ADDR_W     = 5,
   parameter int DATA_W     = 8,
   parameter int WR_ACK_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              as_s,
   input  logic              cs_s,
   input  logic              rnw_s,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic [DATA_W-1:0] data_in,
   input  logic [DATA_W-1:0] rd_byte,
   output logic [ADDR_W-1:0] addr_q,
   output logic              wr_en,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              ack_oe
);
   localparam int CW = $clog2(WR_ACK_LEN + 1);

   if (WR_ACK_LEN < 1) begin : g_bad_ack
      $error("pbus_ctrl: WR_ACK_LEN must be at least 1");
   end

   pbus_state_e state, state_nx;
   logic        as_d, cs_d;
   logic        as_fall, cs_fall, cs_rise;
   logic        rd_cycle;
   logic [CW-1:0] ack_cnt;

   assign as_fall = as_d & ~as_s;
   assign cs_fall = cs_d & ~cs_s;
   assign cs_rise = ~cs_d & cs_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         as_d <= 1'b1;
         cs_d <= 1'b1;
      end else begin
         as_d <= as_s;
         cs_d <= cs_s;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr_q <= '0;
      else if (as_fall) addr_q <= addr_in;
   end

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:     if (cs_fall) state_nx = rnw_s ? ST_RD_DRIVE : ST_WR_WAIT;
         ST_RD_DRIVE: state_nx = cs_rise ? ST_IDLE : ST_RD_ACK;
         ST_RD_ACK:   if (cs_rise) state_nx = ST_IDLE;
         ST_WR_WAIT:  if (cs_rise) state_nx = ST_WR_ACK;
         ST_WR_ACK:   if (ack_cnt == CW'(WR_ACK_LEN - 1)) state_nx = ST_IDLE;
         default:     state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         data_out <= '0;
         rd_cycle <= 1'b0;
         ack_cnt  <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && cs_fall) begin
            rd_cycle <= rnw_s;
            if (rnw_s) data_out <= rd_byte;
         end else if (state_nx == ST_IDLE) begin
            rd_cycle <= 1'b0;
         end
         if (state == ST_WR_ACK) ack_cnt <= ack_cnt + 1'b1;
         else                    ack_cnt <= '0;
      end
   end

   assign wr_en   = (state == ST_WR_WAIT) && cs_rise;
   assign wr_data = data_in;
   assign data_oe = (state == ST_RD_DRIVE) || (state == ST_RD_ACK);
   assign ack_oe  = (state == ST_RD_ACK) || (state == ST_WR_ACK);

   assert_ack_after_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_oe) |=> (ack_oe || !data_oe));

   assert_read_data_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe && $past(data_oe)) |-> $stable(data_out));

   assert_read_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RD_ACK && cs_rise) |=> (!ack_oe && !data_oe));

   assert_no_drive_on_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> rd_cycle);

   assert_write_ack_follows_commit_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (ack_oe && !data_oe));
endmodule

// File: rtl/pbus_reg_slave.sv
module pbus_reg_slave #(
   parameter int ADDR_W      = 5,
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int WR_ACK_LEN  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              serial_mode,
   input  logic [ADDR_W-1:0] hb_addr,
   input  logic              hb_as_n,
   input  logic              hb_cs_n,
   input  logic              hb_rnw,
   input  logic [DATA_W-1:0] hb_data_in,
   output logic [DATA_W-1:0] hb_data_out,
   output logic              hb_data_oe,
   output logic              hb_ack_n,
   output logic              hb_ack_oe
);
   localparam int QUIET_N = SYNC_STAGES + 3;
   localparam int QW      = $clog2(QUIET_N + 1);

   if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
      $error("pbus_reg_slave: ADDR_W out of range");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("pbus_reg_slave: DATA_W must be positive");
   end

   logic [2:0]        raw_ctl, sync_ctl;
   logic [ADDR_W-1:0] addr_q;
   logic              wr_en;
   logic [DATA_W-1:0] wr_data, rd_byte;

   assign raw_ctl = {hb_as_n | serial_mode, hb_cs_n | serial_mode, hb_rnw};

   pbus_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_ctl),
      .q     (sync_ctl)
   );

   pbus_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_ACK_LEN(WR_ACK_LEN)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .as_s     (sync_ctl[2]),
      .cs_s     (sync_ctl[1]),
      .rnw_s    (sync_ctl[0]),
      .addr_in  (hb_addr),
      .data_in  (hb_data_in),
      .rd_byte  (rd_byte),
      .addr_q   (addr_q),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .data_out (hb_data_out),
      .data_oe  (hb_data_oe),
      .ack_oe   (hb_ack_oe)
   );

   pbus_reg_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .addr    (addr_q),
      .wr_data (wr_data),
      .rd_data (rd_byte)
   );

   assign hb_ack_n = ~hb_ack_oe;

   logic [QW-1:0] quiet_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               quiet_cnt <= '0;
      else if (!serial_mode)                    quiet_cnt <= '0;
      else if (quiet_cnt != QW'(QUIET_N))       quiet_cnt <= quiet_cnt + 1'b1;
   end

   assert_serial_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (quiet_cnt == QW'(QUIET_N)) |-> (!hb_data_oe && !hb_ack_oe && !wr_en));
endmodule

// File: tb/pbus_reg_slave_bench.sv
module pbus_reg_slave_bench;
   localparam int AW = 5;
   localparam int DW = 8;
   localparam int NREG = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          serial_mode = 1'b0;
   logic [AW-1:0] hb_addr = '0;
   logic          hb_as_n = 1'b1;
   logic          hb_cs_n = 1'b1;
   logic          hb_rnw = 1'b1;
   logic [DW-1:0] hb_data_in = '0;
   logic [DW-1:0] hb_data_out;
   logic          hb_data_oe, hb_ack_n, hb_ack_oe;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] model [NREG];
   logic ack_seen, ack_bad, oe_seen;

   always #2.5 clk = ~clk;

   pbus_reg_slave u_pbus_reg_slave (
      .clk(clk), .rst_n(rst_n), .serial_mode(serial_mode),
      .hb_addr(hb_addr), .hb_as_n(hb_as_n), .hb_cs_n(hb_cs_n), .hb_rnw(hb_rnw),
      .hb_data_in(hb_data_in), .hb_data_out(hb_data_out), .hb_data_oe(hb_data_oe),
      .hb_ack_n(hb_ack_n), .hb_ack_oe(hb_ack_oe)
   );

   always @(negedge clk) begin
      if (hb_ack_oe) ack_seen <= 1'b1;
      if (hb_ack_oe && hb_ack_n) ack_bad <= 1'b1;
      if (hb_data_oe) oe_seen <= 1'b1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic waitc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic logic [DW-1:0] exp_read(input logic [AW-1:0] a);
      return model[a];
   endfunction

   // write cycle; early_junk puts a wrong byte on the bus at chip-select fall
   task automatic host_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic early_junk, input logic [AW-1:0] addr_move);
      @(negedge clk);
      hb_addr = a; hb_rnw = 1'b0; hb_as_n = 1'b0;
      waitc(6);
      hb_addr = addr_move;
      hb_data_in = early_junk ? ~d : d;
      ack_seen = 1'b0; ack_bad = 1'b0; oe_seen = 1'b0;
      hb_cs_n = 1'b0;
      waitc(3);
      hb_data_in = d;
      waitc(5);
      hb_cs_n = 1'b1;
      waitc(8);
      hb_as_n = 1'b1; hb_rnw = 1'b1;
      waitc(3);
      if (!serial_mode) model[a] = d;
   endtask

   task automatic host_read(input logic [AW-1:0] a, output logic [DW-1:0] d,
                            output logic oe1, output logic ack1, output logic stable);
      logic [DW-1:0] d2;
      @(negedge clk);
      hb_addr = a; hb_rnw = 1'b1; hb_as_n = 1'b0;
      waitc(6);
      hb_cs_n = 1'b0;
      waitc(8);
      d = hb_data_out; oe1 = hb_data_oe; ack1 = hb_ack_oe && !hb_ack_n;
      waitc(3);
      d2 = hb_data_out;
      stable = (d2 == d) && hb_data_oe;
      hb_cs_n = 1'b1;
      waitc(6);
      check("R4 read enable released", {31'd0, hb_data_oe}, 32'd0);
      check("R5 read ack released", {31'd0, hb_ack_oe}, 32'd0);
      hb_as_n = 1'b1;
      waitc(3);
   endtask

   initial begin
      logic [DW-1:0] d;
      logic oe1, ack1, st;
      void'($urandom(32'd2024));
      for (int i = 0; i < NREG; i++) model[i] = '0;
      waitc(4);
      check("R1 data enable at reset", {31'd0, hb_data_oe}, 32'd0);
      check("R1 ack enable at reset", {31'd0, hb_ack_oe}, 32'd0);
      rst_n = 1'b1;
      waitc(4);

      // R1: registers clear
      host_read(5'd0, d, oe1, ack1, st);  check("R1 reg0 zero", d, 0);
      host_read(5'd31, d, oe1, ack1, st); check("R1 reg31 zero", d, 0);

      // R3/R6/R7/R9: write with late-valid data
      host_write(5'd3, 8'hA5, 1'b1, 5'd3);
      check("R6 write ack seen", {31'd0, ack_seen}, 32'd1);
      check("R9 ack level", {31'd0, ack_bad}, 32'd0);
      check("R7 no drive on write", {31'd0, oe_seen}, 32'd0);
      check("R7 idle no drive", {31'd0, hb_data_oe}, 32'd0);
      check("R6 write ack ended", {31'd0, hb_ack_oe}, 32'd0);
      host_read(5'd3, d, oe1, ack1, st);
      check("R3 late data stored", d, 32'hA5);
      check("R4 read enable", {31'd0, oe1}, 32'd1);
      check("R4 read stable", {31'd0, st}, 32'd1);
      check("R5/R9 read ack active low", {31'd0, ack1}, 32'd1);

      // R2: address lines move while strobe held low
      host_write(5'd9, 8'h3C, 1'b0, 5'd20);
      host_read(5'd9, d, oe1, ack1, st);  check("R2 latched target", d, 32'h3C);
      host_read(5'd20, d, oe1, ack1, st); check("R2 other untouched", d, 32'h00);

      // R8: serial mode ignores bus
      serial_mode = 1'b1;
      waitc(4);
      host_write(5'd3, 8'h11, 1'b0, 5'd3);
      check("R8 no ack in serial", {31'd0, ack_seen}, 32'd0);
      check("R8 no drive in serial", {31'd0, oe_seen}, 32'd0);
      serial_mode = 1'b0;
      waitc(6);
      host_read(5'd3, d, oe1, ack1, st);  check("R8 register unchanged", d, 32'hA5);

      // R6: exact write ack length
      host_write(5'd7, 8'h77, 1'b0, 5'd7);
      begin
         int len = 0;
         hb_rnw = 1'b0; hb_addr = 5'd7; hb_as_n = 1'b0;
         waitc(6); hb_data_in = 8'h78; hb_cs_n = 1'b0; waitc(6); hb_cs_n = 1'b1;
         for (int k = 0; k < 12; k++) begin
            waitc(1);
            if (hb_ack_oe) len++;
         end
         hb_as_n = 1'b1; hb_rnw = 1'b1; waitc(3);
         model[7] = 8'h78;
         check("R6 write ack length", len, 2);
      end

      // R10: random traffic against model
      for (int n = 0; n < 120; n++) begin
         logic [AW-1:0] a;
         a = AW'($urandom_range(0, NREG-1));
         if ($urandom_range(0, 1) == 1) begin
            host_write(a, DW'($urandom), 1'($urandom_range(0, 1)), a);
         end else begin
            host_read(a, d, oe1, ack1, st);
            check("R10 random read", d, exp_read(a));
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      #(5ns * 150000);
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule